// File: doc/BRIEF.md
# Narrow Register Access Bridge

This block connects a host bus that makes 8-, 16- and 32-bit register accesses to a peripheral register file that accepts only aligned 32-bit words. Every narrow read becomes one word read, and the addressed lane is returned right-justified. Every narrow write becomes a read-modify-write of the word that contains it. Full-word writes pass straight through.

Two halfword registers of the command group are never written alone. The block-size and block-count halfwords collect in a block shadow word, and the transfer-mode halfword collects in the low half of a command shadow word. When the command halfword is written, the block shadow goes out first as one word, but only if it is non-zero, and it is then cleared. The merged transfer-mode and command word follows it. Each downstream write is followed by a settling stall whose length depends on the configured card clock. This keeps back-to-back writes from reaching the target too close together.

The upstream side uses a request/ready handshake: a request is accepted on a clock edge where `up_req` and `up_ready` are both high. Read data returns with a single-cycle `up_rvalid` pulse. Downstream read data is valid in the cycle after the cycle in which `dn_rd` is high.

Top module: `narrow_access_bridge`

## Requirements
- R1: Every downstream access uses a word-aligned address, equal to the upstream address with its two low bits cleared. `dn_rd` and `dn_wr` are never high together.
- R2: A read performs one downstream word read. The word is shifted right by 8 × addr[1:0] and masked to 8 bits (size 0) or 16 bits (size 1); a size 2 read returns the whole word. The result is presented on `up_rdata` with a single-cycle `up_rvalid` pulse, in the same cycle that `up_ready` rises.
- R3: A byte write (size 0) reads the containing word, replaces only the addressed byte lane with `up_wdata[7:0]`, and writes the word back.
- R4: A halfword write (size 1) to any address other than 0x04, 0x06, 0x0C or 0x0E is a read-modify-write of the addressed 16-bit lane, using `up_wdata[15:0]`.
- R5: A halfword write to 0x04 (block size) or 0x06 (block count) makes no downstream access. It only updates the low or high half of the block shadow, and `up_ready` stays high.
- R6: A halfword write to 0x0C (transfer mode) makes no downstream access. It only updates the low half of the command shadow, and `up_ready` stays high.
- R7: A halfword write to 0x0E (command) proceeds in order. First, if the block shadow is non-zero, it is written at word 0x04 and then cleared. Next, the command halfword is merged into the upper half of the command shadow, and that word is written at 0x0C.
- R8: A size 2 write goes straight through as one downstream write of `up_wdata` at the word address, without touching either shadow.
- R9: When `card_hz` is between 1 and 400000 inclusive, each downstream write is followed by a stall of D = ceil(4·10^6 / card_hz) µs. A word write then holds `up_ready` low for 2 + D·(SYS_CLK_HZ/10^6) cycles, and a read-modify-write holds it low for 4 + D·(SYS_CLK_HZ/10^6) cycles.
- R10: When `card_hz` is 0, the stall after each downstream write is 10 µs.
- R11: When `card_hz` is above 400000, there is no stall, and a word write holds `up_ready` low for exactly 2 cycles.
- R12: After reset, `up_ready` is high, `dn_rd`, `dn_wr` and `up_rvalid` are low, and both shadows are zero. A first command write therefore produces a single write of {cmd, 16'h0000} at 0x0C.
- R13: While `up_ready` is low, no new request is accepted. A request held high during that time produces no downstream access until `up_ready` has risen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| up_req | input | 1 | Upstream request |
| up_we | input | 1 | 1 = write, 0 = read |
| up_size | input | 2 | 0 = byte, 1 = halfword, 2 or 3 = word |
| up_addr | input | AW | Upstream byte address |
| up_wdata | input | 32 | Write data, right-justified |
| card_hz | input | 32 | Configured card clock in Hz |
| up_ready | output | 1 | Bridge can accept a request |
| up_rvalid | output | 1 | Read data valid pulse |
| up_rdata | output | 32 | Read data, right-justified |
| dn_rd | output | 1 | Downstream word read strobe |
| dn_wr | output | 1 | Downstream word write strobe |
| dn_addr | output | AW | Downstream word address |
| dn_wdata | output | 32 | Downstream write data |
| dn_rdata | input | 32 | Downstream read data, valid one cycle after `dn_rd` |

## Verification
The timer assertions assume that `card_hz` only matters at the edge that starts a stall, and that it need not stay stable while a stall runs. The bench changes `card_hz` only while the bridge is idle. The bridge-level properties assume that the downstream side returns read data with a fixed latency of one cycle. The bench's register-file model honours that latency exactly, and it presents only legal size codes at addresses inside its model.

// File: rtl/nb_pkg.sv
package nb_pkg;
  localparam int WORD_W = 32;

  localparam logic [7:0] OFF_BLKSZ  = 8'h04;
  localparam logic [7:0] OFF_BLKCNT = 8'h06;
  localparam logic [7:0] OFF_XFER   = 8'h0C;
  localparam logic [7:0] OFF_CMD    = 8'h0E;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD1,
    ST_RD2,
    ST_WR,
    ST_WAIT
  } br_state_e;

  function automatic logic [WORD_W-1:0] lane_mask(input logic [1:0] size);
    case (size)
      2'd0:    lane_mask = 32'h0000_00FF;
      2'd1:    lane_mask = 32'h0000_FFFF;
      default: lane_mask = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/lane_extract.sv
module lane_extract
  import nb_pkg::*;
(
  input  logic [WORD_W-1:0] base,
  input  logic [1:0]        off,
  input  logic [1:0]        size,
  output logic [WORD_W-1:0] ext
);
  logic [4:0] sh;

  always_comb begin
    sh  = size[1] ? 5'd0 : {off, 3'b000};
    ext = (base >> sh) & lane_mask(size);
  end
endmodule

// File: rtl/lane_merge.sv
module lane_merge
  import nb_pkg::*;
(
  input  logic [WORD_W-1:0] base,
  input  logic [1:0]        off,
  input  logic [1:0]        size,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] merged
);
  logic [4:0]        sh;
  logic [WORD_W-1:0] m;

  always_comb begin
    sh     = size[1] ? 5'd0 : {off, 3'b000};
    m      = lane_mask(size) << sh;
    merged = (base & ~m) | ((wdata & lane_mask(size)) << sh);
  end
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int SYS_CLK_HZ    = 200_000_000,
  parameter int SLOW_LIMIT_HZ = 400_000,
  parameter int CARD_PERIODS  = 4,
  parameter int ZERO_CLK_US   = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [31:0] card_hz,
  output logic        busy
);
  localparam int DIV    = SYS_CLK_HZ / 1_000_000;
  localparam int PW     = $clog2(DIV + 1);
  localparam int US_W   = $clog2(ZERO_CLK_US + 1);
  localparam int THRESH = CARD_PERIODS * 1_000_000;

  logic [PW-1:0]   pre;
  logic [US_W-1:0] us_cnt;
  logic [33:0]     acc;
  logic [31:0]     hz_q;
  logic [US_W-1:0] us_nxt;
  logic [33:0]     acc_nxt;

  always_comb begin
    us_nxt  = us_cnt + 1'b1;
    acc_nxt = acc + {2'b00, hz_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      pre    <= '0;
      us_cnt <= '0;
      acc    <= '0;
      hz_q   <= '0;
    end else if (start) begin
      busy   <= (card_hz <= 32'(SLOW_LIMIT_HZ));
      hz_q   <= card_hz;
      pre    <= '0;
      us_cnt <= '0;
      acc    <= '0;
    end else if (busy) begin
      if (pre == PW'(DIV - 1)) begin
        pre    <= '0;
        us_cnt <= us_nxt;
        acc    <= acc_nxt;
        if (hz_q == 32'd0) begin
          if (us_nxt == US_W'(ZERO_CLK_US)) busy <= 1'b0;
        end else if (acc_nxt >= 34'(THRESH)) begin
          busy <= 1'b0;
        end
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  // R11
  fast_clk_nodelay_chk: assert property (@(posedge clk) disable iff (rst)
    (start && card_hz > 32'(SLOW_LIMIT_HZ)) |=> !busy);

  // R10
  zero_clk_delay_chk: assert property (@(posedge clk) disable iff (rst)
    (start && card_hz == 32'd0) |=> busy);
endmodule

// File: rtl/narrow_access_bridge.sv
module narrow_access_bridge
  import nb_pkg::*;
#(
  parameter int AW            = 8,
  parameter int SYS_CLK_HZ    = 200_000_000,
  parameter int SLOW_LIMIT_HZ = 400_000,
  parameter int CARD_PERIODS  = 4,
  parameter int ZERO_CLK_US   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_req,
  input  logic              up_we,
  input  logic [1:0]        up_size,
  input  logic [AW-1:0]     up_addr,
  input  logic [WORD_W-1:0] up_wdata,
  input  logic [31:0]       card_hz,
  output logic              up_ready,
  output logic              up_rvalid,
  output logic [WORD_W-1:0] up_rdata,
  output logic              dn_rd,
  output logic              dn_wr,
  output logic [AW-1:0]     dn_addr,
  output logic [WORD_W-1:0] dn_wdata,
  input  logic [WORD_W-1:0] dn_rdata
);
  localparam logic [AW-1:0] A_BLKSZ  = AW'(OFF_BLKSZ);
  localparam logic [AW-1:0] A_BLKCNT = AW'(OFF_BLKCNT);
  localparam logic [AW-1:0] A_XFER   = AW'(OFF_XFER);
  localparam logic [AW-1:0] A_CMD    = AW'(OFF_CMD);

  br_state_e         st;
  logic              we_q;
  logic [1:0]        sz_q;
  logic [1:0]        off_q;
  logic [WORD_W-1:0] wd_q;
  logic [WORD_W-1:0] shadow_blk;
  logic [WORD_W-1:0] shadow_cmd;
  logic              cmd_pend;
  logic              tmr_busy;

  logic              accept;
  logic              is_half;
  logic              hit_blk;
  logic              hit_xfer;
  logic              hit_cmd;
  logic [AW-1:0]     up_word;
  logic [WORD_W-1:0] sh_base;
  logic [WORD_W-1:0] sh_merged;
  logic [WORD_W-1:0] rmw_merged;
  logic [WORD_W-1:0] rd_ext;

  always_comb begin
    accept   = up_req && up_ready;
    is_half  = (up_size == 2'd1);
    hit_blk  = is_half && (up_addr == A_BLKSZ || up_addr == A_BLKCNT);
    hit_xfer = is_half && (up_addr == A_XFER);
    hit_cmd  = is_half && (up_addr == A_CMD);
    up_word  = {up_addr[AW-1:2], 2'b00};
    sh_base  = (hit_cmd || hit_xfer) ? shadow_cmd : shadow_blk;
  end

  lane_merge u_sh_merge (
    .base   (sh_base),
    .off    (up_addr[1:0]),
    .size   (up_size),
    .wdata  (up_wdata),
    .merged (sh_merged)
  );

  lane_merge u_rmw_merge (
    .base   (dn_rdata),
    .off    (off_q),
    .size   (sz_q),
    .wdata  (wd_q),
    .merged (rmw_merged)
  );

  lane_extract u_rd_ext (
    .base (dn_rdata),
    .off  (off_q),
    .size (sz_q),
    .ext  (rd_ext)
  );

  settle_timer #(
    .SYS_CLK_HZ    (SYS_CLK_HZ),
    .SLOW_LIMIT_HZ (SLOW_LIMIT_HZ),
    .CARD_PERIODS  (CARD_PERIODS),
    .ZERO_CLK_US   (ZERO_CLK_US)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .start   (st == ST_WR),
    .card_hz (card_hz),
    .busy    (tmr_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      up_ready   <= 1'b1;
      up_rvalid  <= 1'b0;
      up_rdata   <= '0;
      dn_rd      <= 1'b0;
      dn_wr      <= 1'b0;
      dn_addr    <= '0;
      dn_wdata   <= '0;
      we_q       <= 1'b0;
      sz_q       <= '0;
      off_q      <= '0;
      wd_q       <= '0;
      shadow_blk <= '0;
      shadow_cmd <= '0;
      cmd_pend   <= 1'b0;
    end else begin
      dn_rd     <= 1'b0;
      dn_wr     <= 1'b0;
      up_rvalid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            we_q  <= up_we;
            sz_q  <= up_size;
            off_q <= up_addr[1:0];
            wd_q  <= up_wdata;
            if (!up_we) begin
              dn_rd    <= 1'b1;
              dn_addr  <= up_word;
              up_ready <= 1'b0;
              st       <= ST_RD1;
            end else if (up_size[1]) begin
              dn_wr    <= 1'b1;
              dn_addr  <= up_word;
              dn_wdata <= up_wdata;
              up_ready <= 1'b0;
              st       <= ST_WR;
            end else if (hit_blk) begin
              shadow_blk <= sh_merged;
            end else if (hit_xfer) begin
              shadow_cmd <= sh_merged;
            end else if (hit_cmd) begin
              shadow_cmd <= sh_merged;
              dn_wr      <= 1'b1;
              up_ready   <= 1'b0;
              st         <= ST_WR;
              if (shadow_blk != '0) begin
                dn_addr    <= A_BLKSZ;
                dn_wdata   <= shadow_blk;
                shadow_blk <= '0;
                cmd_pend   <= 1'b1;
              end else begin
                dn_addr  <= up_word;
                dn_wdata <= sh_merged;
              end
            end else begin
              dn_rd    <= 1'b1;
              dn_addr  <= up_word;
              up_ready <= 1'b0;
              st       <= ST_RD1;
            end
          end
        end
        ST_RD1: st <= ST_RD2;
        ST_RD2: begin
          if (we_q) begin
            dn_wr    <= 1'b1;
            dn_wdata <= rmw_merged;
            st       <= ST_WR;
          end else begin
            up_rdata  <= rd_ext;
            up_rvalid <= 1'b1;
            up_ready  <= 1'b1;
            st        <= ST_IDLE;
          end
        end
        ST_WR: st <= ST_WAIT;
        ST_WAIT: begin
          if (!tmr_busy) begin
            if (cmd_pend) begin
              dn_wr    <= 1'b1;
              dn_addr  <= A_XFER;
              dn_wdata <= shadow_cmd;
              cmd_pend <= 1'b0;
              st       <= ST_WR;
            end else begin
              up_ready <= 1'b1;
              st       <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R1
  dn_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    (dn_rd || dn_wr) |-> (dn_addr[1:0] == 2'b00));

  // R1
  dn_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(dn_rd && dn_wr));

  // R13
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (dn_rd || dn_wr) |-> !up_ready);

  // R2
  rvalid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    up_rvalid |=> !up_rvalid);

  // R7
  flush_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    (dn_wr && cmd_pend) |-> (shadow_blk == '0));
endmodule

// File: tb/narrow_access_bridge_tb.sv
module narrow_access_bridge_tb;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        up_req = 1'b0;
  logic        up_we = 1'b0;
  logic [1:0]  up_size = 2'd0;
  logic [7:0]  up_addr = 8'h00;
  logic [31:0] up_wdata = 32'h0;
  logic [31:0] card_hz = 32'd25_000_000;
  logic        up_ready;
  logic        up_rvalid;
  logic [31:0] up_rdata;
  logic        dn_rd;
  logic        dn_wr;
  logic [7:0]  dn_addr;
  logic [31:0] dn_wdata;
  logic [31:0] dn_rdata = 32'h0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [31:0] mem    [0:63];
  logic [7:0]  wlog_a [0:63];
  logic [31:0] wlog_d [0:63];
  int          wlog_n = 0;

  always #2.5 clk = ~clk;

  narrow_access_bridge u_dut (
    .clk       (clk),
    .rst       (rst),
    .up_req    (up_req),
    .up_we     (up_we),
    .up_size   (up_size),
    .up_addr   (up_addr),
    .up_wdata  (up_wdata),
    .card_hz   (card_hz),
    .up_ready  (up_ready),
    .up_rvalid (up_rvalid),
    .up_rdata  (up_rdata),
    .dn_rd     (dn_rd),
    .dn_wr     (dn_wr),
    .dn_addr   (dn_addr),
    .dn_wdata  (dn_wdata),
    .dn_rdata  (dn_rdata)
  );

  always @(posedge clk) begin
    if (dn_wr) begin
      mem[dn_addr[7:2]] <= dn_wdata;
      if (wlog_n < 64) begin
        wlog_a[wlog_n] <= dn_addr;
        wlog_d[wlog_n] <= dn_wdata;
      end
      wlog_n <= wlog_n + 1;
    end
    if (dn_rd) dn_rdata <= mem[dn_addr[7:2]];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [1:0] sz, input logic [7:0] a,
                        input logic [31:0] d, output int lowcyc, output logic rv,
                        output logic [31:0] rd);
    @(negedge clk);
    while (!up_ready) @(negedge clk);
    up_req = 1'b1; up_we = we; up_size = sz; up_addr = a; up_wdata = d;
    @(negedge clk);
    up_req = 1'b0;
    lowcyc = 0;
    while (!up_ready) begin
      lowcyc++;
      @(negedge clk);
    end
    rv = up_rvalid;
    rd = up_rdata;
  endtask

  task automatic t_reset;
    chk("R12 ready", {31'b0, up_ready}, 32'd1);
    chk("R12 dn_wr", {31'b0, dn_wr}, 32'd0);
    chk("R12 dn_rd", {31'b0, dn_rd}, 32'd0);
    chk("R12 rvalid", {31'b0, up_rvalid}, 32'd0);
  endtask

  task automatic t_first_cmd;
    int n0 = wlog_n; int lc; logic rv; logic [31:0] rd;
    access(1'b1, 2'd1, 8'h0E, 32'h0000_1234, lc, rv, rd);
    chk("R12 single write", 32'(wlog_n - n0), 32'd1);
    chk("R12 cmd addr", {24'b0, wlog_a[n0]}, 32'h0C);
    chk("R12 cmd data", wlog_d[n0], 32'h1234_0000);
    chk("R11 cmd ready low", 32'(lc), 32'd2);
  endtask

  task automatic t_word_write;
    int n0 = wlog_n; int lc; logic rv; logic [31:0] rd;
    access(1'b1, 2'd2, 8'h30, 32'hDEAD_BEEF, lc, rv, rd);
    chk("R8 addr", {24'b0, wlog_a[n0]}, 32'h30);
    chk("R8 data", wlog_d[n0], 32'hDEAD_BEEF);
    chk("R11 word ready low", 32'(lc), 32'd2);
    access(1'b1, 2'd2, 8'h10, 32'hA1B2_C3D4, lc, rv, rd);
    access(1'b1, 2'd2, 8'h20, 32'h1122_3344, lc, rv, rd);
    chk("R8 write count", 32'(wlog_n - n0), 32'd3);
  endtask

  task automatic t_reads;
    int lc; logic rv; logic [31:0] rd;
    access(1'b0, 2'd0, 8'h11, 32'h0, lc, rv, rd);
    chk("R2 byte1 data", rd, 32'h0000_00C3);
    chk("R2 rvalid", {31'b0, rv}, 32'd1);
    chk("R2 read ready low", 32'(lc), 32'd2);
    access(1'b0, 2'd0, 8'h13, 32'h0, lc, rv, rd);
    chk("R2 byte3 data", rd, 32'h0000_00A1);
    access(1'b0, 2'd1, 8'h12, 32'h0, lc, rv, rd);
    chk("R2 half hi data", rd, 32'h0000_A1B2);
    access(1'b0, 2'd2, 8'h10, 32'h0, lc, rv, rd);
    chk("R2 word data", rd, 32'hA1B2_C3D4);
  endtask

  task automatic t_byte_write;
    int n0 = wlog_n; int lc; logic rv; logic [31:0] rd;
    access(1'b1, 2'd0, 8'h13, 32'hFFFF_FF5A, lc, rv, rd);
    chk("R3 addr", {24'b0, wlog_a[n0]}, 32'h10);
    chk("R3 data", wlog_d[n0], 32'h5AB2_C3D4);
    chk("R3 ready low", 32'(lc), 32'd4);
  endtask

  task automatic t_half_write;
    int n0 = wlog_n; int lc; logic rv; logic [31:0] rd;
    access(1'b1, 2'd1, 8'h20, 32'h7777_BEEF, lc, rv, rd);
    chk("R4 addr", {24'b0, wlog_a[n0]}, 32'h20);
    chk("R4 data", wlog_d[n0], 32'h1122_BEEF);
    access(1'b0, 2'd2, 8'h20, 32'h0, lc, rv, rd);
    chk("R4 readback", rd, 32'h1122_BEEF);
  endtask

  task automatic t_shadow;
    int n0 = wlog_n; int lc; logic rv; logic [31:0] rd;
    access(1'b1, 2'd1, 8'h04, 32'h0000_0200, lc, rv, rd);
    chk("R5 size ready", 32'(lc), 32'd0);
    access(1'b1, 2'd1, 8'h06, 32'h0000_0008, lc, rv, rd);
    chk("R5 count ready", 32'(lc), 32'd0);
    access(1'b1, 2'd1, 8'h0C, 32'h0000_0013, lc, rv, rd);
    chk("R6 mode ready", 32'(lc), 32'd0);
    @(negedge clk);
    chk("R5 R6 no writes", 32'(wlog_n - n0), 32'd0);
    access(1'b1, 2'd1, 8'h0E, 32'h0000_0C3A, lc, rv, rd);
    chk("R7 two writes", 32'(wlog_n - n0), 32'd2);
    chk("R7 blk addr", {24'b0, wlog_a[n0]}, 32'h04);
    chk("R7 blk data", wlog_d[n0], 32'h0008_0200);
    chk("R7 cmd addr", {24'b0, wlog_a[n0+1]}, 32'h0C);
    chk("R7 cmd data", wlog_d[n0+1], 32'h0C3A_0013);
    chk("R7 ready low", 32'(lc), 32'd4);
    access(1'b1, 2'd1, 8'h0E, 32'h0000_0111, lc, rv, rd);
    chk("R7 cleared one write", 32'(wlog_n - n0), 32'd3);
    chk("R7 second cmd data", wlog_d[n0+2], 32'h0111_0013);
  endtask

  task automatic t_hold_req;
    int n0 = wlog_n; int lc; logic rv; logic [31:0] rd;
    @(negedge clk);
    up_req = 1'b1; up_we = 1'b1; up_size = 2'd2; up_addr = 8'h38; up_wdata = 32'h1;
    @(negedge clk);
    up_addr = 8'h3C; up_wdata = 32'h2;
    while (!up_ready) @(negedge clk);
    chk("R13 held req not taken", 32'(wlog_n - n0), 32'd1);
    @(negedge clk);
    up_req = 1'b0;
    while (!up_ready) @(negedge clk);
    chk("R13 second taken", 32'(wlog_n - n0), 32'd2);
    chk("R13 second data", wlog_d[n0+1], 32'h2);
    access(1'b0, 2'd2, 8'h38, 32'h0, lc, rv, rd);
    chk("R13 first data", rd, 32'h1);
  endtask

  task automatic t_delays;
    int lc; logic rv; logic [31:0] rd; int n0;
    card_hz = 32'd400_000;
    access(1'b1, 2'd2, 8'h30, 32'h5, lc, rv, rd);
    chk("R9 400k word", 32'(lc), 32'd2002);
    access(1'b1, 2'd0, 8'h30, 32'h6, lc, rv, rd);
    chk("R9 400k rmw", 32'(lc), 32'd2004);
    card_hz = 32'd300_000;
    access(1'b1, 2'd2, 8'h30, 32'h7, lc, rv, rd);
    chk("R9 300k word", 32'(lc), 32'd2802);
    card_hz = 32'd0;
    access(1'b1, 2'd2, 8'h30, 32'h8, lc, rv, rd);
    chk("R10 zero clk word", 32'(lc), 32'd2002);
    card_hz = 32'd400_001;
    access(1'b1, 2'd2, 8'h30, 32'h9, lc, rv, rd);
    chk("R11 above limit word", 32'(lc), 32'd2);
    card_hz = 32'd100_000;
    n0 = wlog_n;
    access(1'b1, 2'd1, 8'h04, 32'h1, lc, rv, rd);
    access(1'b1, 2'd1, 8'h0E, 32'h1, lc, rv, rd);
    chk("R9 flush stall", 32'(lc), 32'd16004);
    chk("R7 flush writes", 32'(wlog_n - n0), 32'd2);
    card_hz = 32'd25_000_000;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_first_cmd();
    t_word_write();
    t_reads();
    t_byte_write();
    t_half_write();
    t_shadow();
    t_hold_req();
    t_delays();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule